// File: doc/BRIEF.md
# Model-specific register bank

This block is a privileged bank of configuration and timing registers for a small CPU core. The core reaches it over one access channel. Each request carries a 32-bit register number, a read or write flag, the requester's privilege level and 64 bits of write data as two 32-bit halves. Each accepted request gets one response. A read returns the register contents split into high and low halves. A write returns zero data.

Three registers live in the bank:
- A 64-bit cycle counter that software can load.
- A base register for the local interrupt controller, holding a 4 KB page number, an enable bit and a read-only flag that marks the bootstrap processor.
- An extended feature register whose long-mode-active bit is derived in hardware from the paging-enable and address-extension inputs.

The counter is also driven onto a dedicated read port with no privilege check. Requests from a privilege level other than 0, and requests for unknown register numbers, raise a fault and change nothing.

The access channel is valid/ready. A request is accepted on a clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` is high whenever the response slot is empty or the slot is being drained in that cycle (`rsp_ready` high). A response stays valid, and its data and fault flag stay stable, until the cycle in which `rsp_ready` is high. Control and status pins are plain levels.

Top module: `msr_bank`

## Requirements
- R1: The counter (register number 0x10) is 0 while reset is held and grows by exactly one on every clock edge after reset, carrying from the low half into the high half.
- R2: A privileged write to 0x10 loads {write high, write low} into the counter. In that cycle the loaded value replaces the increment. Counting resumes from the loaded value on the next edge.
- R3: After reset, register 0x1B reads with bits 31:12 = 0xFEE00, bit 11 (enable) = 1 and bit 8 = the bootstrap strap input as sampled during reset. The high half reads 0.
- R4: A privileged write to 0x1B updates bits 31:12 and bit 11 from the low write half. Bit 8, all other low bits and the whole high half are not written, and the reserved bits read as 0.
- R5: Register 0xC0000080 resets to 0. A privileged write updates only bit 0 (fast system call enable), bit 8 (long-mode enable) and bit 11 (execute-disable enable). Every other bit reads 0, except bit 10.
- R6: Bit 10 of 0xC0000080 and the `long_mode_active` output equal, one clock edge later, the AND of long-mode enable, `paging_on` and `addr_ext_on`. Writing bit 10 has no effect.
- R7: An access whose privilege level is not 0 is answered with the fault flag set and zero data. No register changes.
- R8: An access to any register number other than 0x10, 0x1B and 0xC0000080 is answered with the fault flag set and zero data. No register changes.
- R9: `fault` is high for exactly the one cycle after a faulting request is accepted. `rsp_fault` marks the matching response.
- R10: The `tsc_hi`/`tsc_lo` port always shows the counter, whatever privilege level the requests carry. A privileged read of 0x10 returns the value the port showed in the accept cycle.
- R11: While a response is valid and `rsp_ready` is low, `acc_ready` is low and the response holds its data. A new request is accepted once the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsp_strap | input | 1 | Bootstrap-processor strap, sampled while reset is held |
| paging_on | input | 1 | Paging enabled by the core |
| addr_ext_on | input | 1 | Physical address extension enabled by the core |
| acc_valid | input | 1 | Request valid |
| acc_ready | output | 1 | Request can be accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cpl | input | 2 | Privilege level of the requester |
| acc_idx | input | 32 | Register number |
| acc_wdata_hi | input | 32 | Write data, bits 63:32 |
| acc_wdata_lo | input | 32 | Write data, bits 31:0 |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 1 | Response belongs to a faulting request |
| rsp_data_hi | output | 32 | Read data, bits 63:32 |
| rsp_data_lo | output | 32 | Read data, bits 31:0 |
| fault | output | 1 | One-cycle fault pulse |
| long_mode_active | output | 1 | Long mode currently active |
| tsc_hi | output | 32 | Counter bits 63:32 |
| tsc_lo | output | 32 | Counter bits 31:0 |

## Verification
The case that needs care is a software load of the counter in the same cycle as its own increment. The bench writes 0x1_FFFFFFFF into the counter. It expects to see exactly that value one cycle later, and 0x2_00000000 the cycle after. So the increment was dropped on the load edge, and the carry into the high half works afterwards. A second overlap pairs clearing long-mode enable with active paging and address extension. The derived active bit must stay high for one more cycle, then fall.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned FULL_W = 2 * HALF_W;
  localparam int unsigned IDX_W  = 32;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned PAGE_W   = HALF_W - PAGE_LSB;

  localparam logic [IDX_W-1:0] IDX_TSC  = 32'h0000_0010;
  localparam logic [IDX_W-1:0] IDX_APIC = 32'h0000_001B;
  localparam logic [IDX_W-1:0] IDX_EFER = 32'hC000_0080;

  localparam int unsigned APIC_EN_BIT  = 11;
  localparam int unsigned APIC_BSP_BIT = 8;
  localparam int unsigned EFER_SCE_BIT = 0;
  localparam int unsigned EFER_LME_BIT = 8;
  localparam int unsigned EFER_LMA_BIT = 10;
  localparam int unsigned EFER_NXE_BIT = 11;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TSC  = 2'd1,
    SEL_APIC = 2'd2,
    SEL_EFER = 2'd3
  } msr_sel_e;
endpackage

// File: rtl/msr_decode.sv
module msr_decode
  import msr_pkg::*;
#(
  parameter int unsigned CPL_W = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [CPL_W-1:0] cpl,
  output msr_sel_e         sel,
  output logic             bad
);
  always_comb begin
    unique case (idx)
      IDX_TSC:  sel = SEL_TSC;
      IDX_APIC: sel = SEL_APIC;
      IDX_EFER: sel = SEL_EFER;
      default:  sel = SEL_NONE;
    endcase
    bad = (cpl != '0) || (sel == SEL_NONE);
  end
endmodule

// File: rtl/msr_tsc.sv
module msr_tsc #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else           cnt_q <= cnt_q + ONE;
  end

  assign cnt = cnt_q;

  // R1
  tsc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt_q == $past(cnt_q) + ONE);
  // R2
  tsc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/msr_ctrl_regs.sv
module msr_ctrl_regs
  import msr_pkg::*;
#(
  parameter logic [PAGE_W-1:0] PAGE_RST = 20'hFEE00,
  parameter bit                EN_RST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsp_strap,
  input  logic              paging_on,
  input  logic              addr_ext_on,
  input  logic              apic_we,
  input  logic              efer_we,
  input  logic [HALF_W-1:0] wdata,
  output logic [FULL_W-1:0] apic_val,
  output logic [FULL_W-1:0] efer_val,
  output logic              lma
);
  logic [PAGE_W-1:0] page_q;
  logic en_q, bsp_q, sce_q, lme_q, nxe_q, lma_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PAGE_RST;
      en_q   <= EN_RST;
      bsp_q  <= bsp_strap;
      sce_q  <= 1'b0;
      lme_q  <= 1'b0;
      nxe_q  <= 1'b0;
      lma_q  <= 1'b0;
    end else begin
      if (apic_we) begin
        page_q <= wdata[HALF_W-1:PAGE_LSB];
        en_q   <= wdata[APIC_EN_BIT];
      end
      if (efer_we) begin
        sce_q <= wdata[EFER_SCE_BIT];
        lme_q <= wdata[EFER_LME_BIT];
        nxe_q <= wdata[EFER_NXE_BIT];
      end
      lma_q <= lme_q & paging_on & addr_ext_on;
    end
  end

  always_comb begin
    apic_val = '0;
    apic_val[HALF_W-1:PAGE_LSB] = page_q;
    apic_val[APIC_EN_BIT]       = en_q;
    apic_val[APIC_BSP_BIT]      = bsp_q;
    efer_val = '0;
    efer_val[EFER_SCE_BIT] = sce_q;
    efer_val[EFER_LME_BIT] = lme_q;
    efer_val[EFER_LMA_BIT] = lma_q;
    efer_val[EFER_NXE_BIT] = nxe_q;
  end

  assign lma = lma_q;

  // R3
  bsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bsp_q));
  // R7
  apic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apic_we |=> $stable(page_q) && $stable(en_q));
  // R8
  efer_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !efer_we |=> $stable(sce_q) && $stable(lme_q) && $stable(nxe_q));
  // R6
  lma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lma_q |-> $past(paging_on) && $past(addr_ext_on) && $past(lme_q));
endmodule

// File: rtl/msr_bank.sv
module msr_bank
  import msr_pkg::*;
#(
  parameter int unsigned CPL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsp_strap,
  input  logic              paging_on,
  input  logic              addr_ext_on,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [CPL_W-1:0]  acc_cpl,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [HALF_W-1:0] acc_wdata_hi,
  input  logic [HALF_W-1:0] acc_wdata_lo,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [HALF_W-1:0] rsp_data_hi,
  output logic [HALF_W-1:0] rsp_data_lo,
  output logic              fault,
  output logic              long_mode_active,
  output logic [HALF_W-1:0] tsc_hi,
  output logic [HALF_W-1:0] tsc_lo
);
  msr_sel_e          sel;
  logic              bad, fire, wr_ok;
  logic [FULL_W-1:0] tsc_val, apic_val, efer_val, rd_val;
  logic              rsp_valid_q, rsp_fault_q, fault_q;
  logic [FULL_W-1:0] rsp_data_q;

  assign acc_ready = !rsp_valid_q || rsp_ready;
  assign fire      = acc_valid && acc_ready;
  assign wr_ok     = fire && acc_write && !bad;

  msr_decode #(.CPL_W(CPL_W)) u_dec (
    .idx (acc_idx),
    .cpl (acc_cpl),
    .sel (sel),
    .bad (bad)
  );

  msr_tsc #(.W(FULL_W)) u_tsc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_ok && sel == SEL_TSC),
    .load_val ({acc_wdata_hi, acc_wdata_lo}),
    .cnt      (tsc_val)
  );

  msr_ctrl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bsp_strap   (bsp_strap),
    .paging_on   (paging_on),
    .addr_ext_on (addr_ext_on),
    .apic_we     (wr_ok && sel == SEL_APIC),
    .efer_we     (wr_ok && sel == SEL_EFER),
    .wdata       (acc_wdata_lo),
    .apic_val    (apic_val),
    .efer_val    (efer_val),
    .lma         (long_mode_active)
  );

  always_comb begin
    rd_val = '0;
    if (!bad && !acc_write) begin
      unique case (sel)
        SEL_TSC:  rd_val = tsc_val;
        SEL_APIC: rd_val = apic_val;
        SEL_EFER: rd_val = efer_val;
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_data_q  <= '0;
      fault_q     <= 1'b0;
    end else begin
      fault_q <= fire && bad;
      if (fire) begin
        rsp_valid_q <= 1'b1;
        rsp_fault_q <= bad;
        rsp_data_q  <= rd_val;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_fault   = rsp_fault_q;
  assign rsp_data_hi = rsp_data_q[FULL_W-1:HALF_W];
  assign rsp_data_lo = rsp_data_q[HALF_W-1:0];
  assign fault       = fault_q;
  assign tsc_hi      = tsc_val[FULL_W-1:HALF_W];
  assign tsc_lo      = tsc_val[HALF_W-1:0];

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data_q) && $stable(rsp_fault));
  // R9
  fault_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_data_q == '0);
  // R9
  fault_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> rsp_valid && rsp_fault);
endmodule

// File: tb/msr_bank_bench.sv
module msr_bank_bench;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        wr;
    logic [1:0]  cpl;
    logic [31:0] idx;
    logic [31:0] hi;
    logic [31:0] lo;
    logic        flt;
    logic [31:0] ehi;
    logic [31:0] elo;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 32'h1B,        32'h0,        32'h0,        1'b0, 32'h0, 32'hFEE00900}, // R3
    '{1'b1, 2'd0, 32'h1B,        32'hFFFFFFFF, 32'h000D80FF, 1'b0, 32'h0, 32'h0},        // R4
    '{1'b0, 2'd0, 32'h1B,        32'h0,        32'h0,        1'b0, 32'h0, 32'h000D8100}, // R4
    '{1'b1, 2'd3, 32'h1B,        32'h0,        32'hFEE00800, 1'b1, 32'h0, 32'h0},        // R7
    '{1'b0, 2'd0, 32'h1B,        32'h0,        32'h0,        1'b0, 32'h0, 32'h000D8100}, // R7
    '{1'b1, 2'd0, 32'hC0000080,  32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h0, 32'h0},        // R5
    '{1'b0, 2'd0, 32'hC0000080,  32'h0,        32'h0,        1'b0, 32'h0, 32'h00000901}, // R5
    '{1'b0, 2'd0, 32'h11,        32'h0,        32'h0,        1'b1, 32'h0, 32'h0},        // R8
    '{1'b1, 2'd0, 32'h1C,        32'h0,        32'h1,        1'b1, 32'h0, 32'h0},        // R8
    '{1'b0, 2'd1, 32'hC0000080,  32'h0,        32'h0,        1'b1, 32'h0, 32'h0},        // R7
    '{1'b1, 2'd0, 32'hC0000080,  32'h0,        32'h00000100, 1'b0, 32'h0, 32'h0},        // R5
    '{1'b0, 2'd0, 32'hC0000080,  32'h0,        32'h0,        1'b0, 32'h0, 32'h00000100}  // R5
  };

  logic clk = 1'b0, rst_n = 1'b0, bsp_strap = 1'b1, paging_on = 1'b0, addr_ext_on = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0] acc_cpl = '0;
  logic [31:0] acc_idx = '0, acc_wdata_hi = '0, acc_wdata_lo = '0;
  logic acc_ready, rsp_valid, rsp_fault, fault, long_mode_active;
  logic [31:0] rsp_data_hi, rsp_data_lo, tsc_hi, tsc_lo;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  msr_bank u_msr_bank (
    .clk(clk), .rst_n(rst_n), .bsp_strap(bsp_strap), .paging_on(paging_on),
    .addr_ext_on(addr_ext_on), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_cpl(acc_cpl), .acc_idx(acc_idx),
    .acc_wdata_hi(acc_wdata_hi), .acc_wdata_lo(acc_wdata_lo),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_data_hi(rsp_data_hi), .rsp_data_lo(rsp_data_lo), .fault(fault),
    .long_mode_active(long_mode_active), .tsc_hi(tsc_hi), .tsc_lo(tsc_lo)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Issue one request at a negedge; check the response one negedge later.
  task automatic access(input string req, input logic wr, input logic [1:0] cpl,
                        input logic [31:0] idx, input logic [31:0] hi, input logic [31:0] lo,
                        input logic eflt, input logic [63:0] edata);
    acc_valid = 1'b1; acc_write = wr; acc_cpl = cpl; acc_idx = idx;
    acc_wdata_hi = hi; acc_wdata_lo = lo;
    step();
    acc_valid = 1'b0;
    chk({req, " rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
    chk({req, " fault flag"}, {62'd0, rsp_fault, fault}, {62'd0, eflt, eflt});
    chk({req, " data"}, {rsp_data_hi, rsp_data_lo}, edata);
  endtask

  initial begin
    logic [63:0] t;
    logic [63:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 counter in reset", {tsc_hi, tsc_lo}, 64'd0);
    chk("R9 outputs in reset", {61'd0, rsp_valid, fault, long_mode_active}, 64'd0);
    rst_n = 1'b1;
    step();
    t = {tsc_hi, tsc_lo};
    step();
    chk("R1 increment", {tsc_hi, tsc_lo}, t + 64'd1);

    for (int i = 0; i < NV; i++) begin
      access("R3/R4/R5/R7/R8 vector", VEC[i].wr, VEC[i].cpl, VEC[i].idx, VEC[i].hi,
             VEC[i].lo, VEC[i].flt, {VEC[i].ehi, VEC[i].elo});
    end

    // R9 pulse lasts one cycle
    access("R9 bad read", 1'b0, 2'd0, 32'h0, 32'h0, 32'h0, 1'b1, 64'd0);
    step();
    chk("R9 pulse ends", {63'd0, fault}, 64'd0);

    // R10 read of counter matches port, and port counts during unprivileged traffic
    t = {tsc_hi, tsc_lo};
    access("R10 counter read", 1'b0, 2'd0, 32'h10, 32'h0, 32'h0, 1'b0, t);
    t = {tsc_hi, tsc_lo};
    access("R10 ring3 counter read", 1'b0, 2'd3, 32'h10, 32'h0, 32'h0, 1'b1, 64'd0);
    chk("R10 port keeps counting", {tsc_hi, tsc_lo}, t + 64'd1);

    // R2 load beats increment, then carry
    access("R2 counter write", 1'b1, 2'd0, 32'h10, 32'h1, 32'hFFFFFFFF, 1'b0, 64'd0);
    chk("R2 loaded value", {tsc_hi, tsc_lo}, 64'h1_FFFFFFFF);
    step();
    chk("R2 carry after load", {tsc_hi, tsc_lo}, 64'h2_00000000);
    // R7 unprivileged counter write ignored
    t = {tsc_hi, tsc_lo};
    access("R7 ring2 counter write", 1'b1, 2'd2, 32'h10, 32'h0, 32'h5, 1'b1, 64'd0);
    chk("R7 counter untouched", {tsc_hi, tsc_lo}, t + 64'd1);

    // R6 long mode active (long-mode enable is 1 from the vectors)
    paging_on = 1'b1;
    step();
    chk("R6 paging only", {63'd0, long_mode_active}, 64'd0);
    addr_ext_on = 1'b1;
    step();
    chk("R6 active", {63'd0, long_mode_active}, 64'd1);
    access("R6 read bit10", 1'b0, 2'd0, 32'hC0000080, 32'h0, 32'h0, 1'b0, 64'h500);
    access("R6 clear enable", 1'b1, 2'd0, 32'hC0000080, 32'h0, 32'h400, 1'b0, 64'd0);
    chk("R6 lags one edge", {63'd0, long_mode_active}, 64'd1);
    step();
    chk("R6 falls", {63'd0, long_mode_active}, 64'd0);
    access("R6 write bit10 ignored", 1'b0, 2'd0, 32'hC0000080, 32'h0, 32'h0, 1'b0, 64'd0);

    // R11 back-pressure
    rsp_ready = 1'b0;
    acc_valid = 1'b1; acc_write = 1'b0; acc_cpl = 2'd0; acc_idx = 32'h1B;
    step();
    acc_valid = 1'b0;
    chk("R11 ready low while held", {62'd0, rsp_valid, acc_ready}, 64'd2);
    held = {rsp_data_hi, rsp_data_lo};
    step();
    chk("R11 data held", {rsp_data_hi, rsp_data_lo}, held);
    chk("R11 still valid", {63'd0, rsp_valid}, 64'd1);
    rsp_ready = 1'b1;
    step();
    chk("R11 drained", {63'd0, rsp_valid}, 64'd0);

    // R3 strap low sampled at reset
    bsp_strap = 1'b0;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    bsp_strap = 1'b1;
    step();
    access("R3 strap low", 1'b0, 2'd0, 32'h1B, 32'h0, 32'h0, 1'b0, 64'hFEE00800);
    access("R5 reset value", 1'b0, 2'd0, 32'hC0000080, 32'h0, 32'h0, 1'b0, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule